// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit unsigned operands and a carry input in pure combinational logic, giving a 16-bit sum and a carry output. No carry travels from one bit to the next. Each bit cell forms a generate term (A AND B) and a propagate term (A OR B). It also forms its own sum bit as A XOR B XOR carry, kept apart from the propagate term.

The 16 bits are split into four groups of four. Each group has a lookahead unit that works out the group's internal carries from the generate terms, the propagate terms and the group's carry-in, each carry as a flat sum of products. The unit also produces a group propagate and a group generate. A second lookahead level takes the four group propagate/generate pairs and the carry input and produces the carry into each group and the final carry-out, again as flat sums of products.

The block has no clock or state. It is placed between registers of the surrounding logic, and its result is valid once the inputs have settled.

Top module: `cla_adder`

## Requirements
- R1: For every input combination, {cout_o, sum_o} equals the 17-bit value a_i + b_i + cin_i. All operands are unsigned, and cout_o is the most significant bit.
- R2: A carry from a generating bit pair at the top of one 4-bit group (bits 3, 7, 11, 15) is taken into the next group or into cout_o. For example, 0x0008 + 0x0008 gives 0x0010 with cout_o = 0, and 0x8000 + 0x8000 gives 0x0000 with cout_o = 1.
- R3: Full propagate chain. With a_i = 0x0000 and b_i = 0xFFFF, cin_i = 0 gives sum 0xFFFF with cout_o = 0, and cin_i = 1 gives sum 0x0000 with cout_o = 1.
- R4: Alternating propagate chain. With a_i = 0x5555 and b_i = 0xAAAA, cin_i = 0 gives sum 0xFFFF with cout_o = 0, and cin_i = 1 gives sum 0x0000 with cout_o = 1.
- R5: Every carry that enters a bit equals the generate term of the bit below it, ORed with that bit's propagate term ANDed with that bit's own carry-in. The same relation holds between group generate, group propagate and group carry-in at the second level, and the top carry is cout_o.
- R6: When every bit pair generates (0xFFFF + 0xFFFF), cout_o = 1 whatever cin_i is. The sum is 0xFFFE when cin_i = 0 and 0xFFFF when cin_i = 1.
- R7: With both operands zero, the sum equals cin_i and cout_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The checks run as soon as the inputs change and assume that all three inputs hold defined 0/1 values. A floating operand would make the arithmetic comparison meaningless. The bench drives every input from time zero, holding the operands at zero during reset. It changes the inputs only on the falling clock edge, so the sum has settled before anything compares it. Directed vectors cover the propagate chains, the all-generate case and each group boundary. Random operands with a random carry input fill in the rest.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned GROUP_W  = 4;
    localparam int unsigned N_GROUPS = 4;
    localparam int unsigned WIDTH    = GROUP_W * N_GROUPS;

    typedef struct packed {
        logic pg;
        logic gg;
    } grp_pg_t;
endpackage

// File: rtl/cla_pfa.sv
module cla_pfa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic g_o,
    output logic p_o
);
    always_comb begin
        g_o = a_i & b_i;
        p_o = a_i | b_i;
        s_o = a_i ^ b_i ^ c_i;
    end
endmodule

// File: rtl/cla_lookahead.sv
// Flat sum-of-products lookahead over N generate/propagate pairs.
// carry_o[0] is the incoming carry; carry_o[j] is the carry into position j.
// The carry out of the top position is not produced here.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    input  logic         c_i,
    output logic [N-1:0] carry_o,
    output logic         pg_o,
    output logic         gg_o
);
    always_comb begin
        carry_o = '0;
        carry_o[0] = c_i;
        for (int j = 1; j < int'(N); j++) begin
            logic acc;
            logic term;
            term = c_i;
            for (int m = 0; m < j; m++) term = term & p_i[m];
            acc = term;
            for (int i = 0; i < j; i++) begin
                term = g_i[i];
                for (int m = i + 1; m < j; m++) term = term & p_i[m];
                acc = acc | term;
            end
            carry_o[j] = acc;
        end
    end

    always_comb begin
        pg_o = &p_i;
        gg_o = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            logic term;
            term = g_i[i];
            for (int m = i + 1; m < int'(N); m++) term = term & p_i[m];
            gg_o = gg_o | term;
        end
    end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_i,
    output logic [GW-1:0] s_o,
    output logic [GW-1:0] g_o,
    output logic [GW-1:0] p_o,
    output logic [GW-1:0] c_o,
    output logic          pg_o,
    output logic          gg_o
);
    cla_lookahead #(.N(GW)) u_la (
        .g_i    (g_o),
        .p_i    (p_o),
        .c_i    (cin_i),
        .carry_o(c_o),
        .pg_o   (pg_o),
        .gg_o   (gg_o)
    );

    for (genvar i = 0; i < int'(GW); i++) begin : g_bit
        cla_pfa u_pfa (
            .a_i(a_i[i]),
            .b_i(b_i[i]),
            .c_i(c_o[i]),
            .s_o(s_o[i]),
            .g_o(g_o[i]),
            .p_o(p_o[i])
        );
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
(
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int unsigned TOP_N = N_GROUPS + 1;

    logic [WIDTH-1:0]    bit_g;
    logic [WIDTH-1:0]    bit_p;
    logic [WIDTH-1:0]    bit_c;
    grp_pg_t [N_GROUPS-1:0] grp;
    logic [N_GROUPS-1:0] grp_pg;
    logic [N_GROUPS-1:0] grp_gg;
    logic [N_GROUPS:0]   grp_c;
    logic [TOP_N-1:0]    top_carry;
    logic                top_pg_unused;
    logic                top_gg_unused;

    for (genvar k = 0; k < int'(N_GROUPS); k++) begin : g_grp
        cla_group #(.GW(GROUP_W)) u_grp (
            .a_i  (a_i[k*GROUP_W +: GROUP_W]),
            .b_i  (b_i[k*GROUP_W +: GROUP_W]),
            .cin_i(grp_c[k]),
            .s_o  (sum_o[k*GROUP_W +: GROUP_W]),
            .g_o  (bit_g[k*GROUP_W +: GROUP_W]),
            .p_o  (bit_p[k*GROUP_W +: GROUP_W]),
            .c_o  (bit_c[k*GROUP_W +: GROUP_W]),
            .pg_o (grp[k].pg),
            .gg_o (grp[k].gg)
        );
        assign grp_pg[k] = grp[k].pg;
        assign grp_gg[k] = grp[k].gg;
    end

    // Second level: an extra dummy position lets the shared lookahead
    // produce the final carry as its top carry in the same flat form.
    cla_lookahead #(.N(TOP_N)) u_top (
        .g_i    ({1'b0, grp_gg}),
        .p_i    ({1'b0, grp_pg}),
        .c_i    (cin_i),
        .carry_o(top_carry),
        .pg_o   (top_pg_unused),
        .gg_o   (top_gg_unused)
    );

    assign grp_c  = top_carry;
    assign cout_o = grp_c[N_GROUPS];
endmodule

// File: rtl/cla_adder_checker.sv
module cla_adder_checker
    import cla_pkg::*;
(
    input logic [WIDTH-1:0]    a_i,
    input logic [WIDTH-1:0]    b_i,
    input logic                cin_i,
    input logic [WIDTH-1:0]    sum_o,
    input logic                cout_o,
    input logic [WIDTH-1:0]    bit_g,
    input logic [WIDTH-1:0]    bit_p,
    input logic [WIDTH-1:0]    bit_c,
    input logic [N_GROUPS-1:0] grp_pg,
    input logic [N_GROUPS-1:0] grp_gg,
    input logic [N_GROUPS:0]   grp_c
);
    logic [WIDTH:0] ref_sum;
    always_comb ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    // R1
    always_comb p_sum_exact_r1: assert ({cout_o, sum_o} == ref_sum);

    // R5: bit level ripple relation holds for every lookahead carry
    always_comb begin
        for (int i = 0; i + 1 < int'(WIDTH); i++) begin
            p_bit_carry_r5: assert (bit_c[i+1] == (bit_g[i] | (bit_p[i] & bit_c[i])));
        end
    end

    // R5: second level carries match group generate/propagate and feed the groups
    always_comb begin
        for (int k = 0; k < int'(N_GROUPS); k++) begin
            p_grp_carry_r5: assert (grp_c[k+1] == (grp_gg[k] | (grp_pg[k] & grp_c[k])));
            p_grp_entry_r5: assert (bit_c[k*GROUP_W] == grp_c[k]);
        end
        p_cout_link_r5: assert (cout_o == grp_c[N_GROUPS]);
    end

    // R6: all bits generating forces a carry out
    always_comb p_all_gen_r6: assert (!(&bit_g) || cout_o);

    // R3: all bits propagating passes the carry input straight to the output
    always_comb p_all_prop_r3: assert (!(&grp_pg) || (cout_o == (cin_i | (|grp_gg))));
endmodule

bind cla_adder cla_adder_checker u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .sum_o (sum_o),
    .cout_o(cout_o),
    .bit_g (bit_g),
    .bit_p (bit_p),
    .bit_c (bit_c),
    .grp_pg(grp_pg),
    .grp_gg(grp_gg),
    .grp_c (grp_c)
);

// File: tb/test_cla_adder.sv
`timescale 1ns/1ps
module test_cla_adder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a   = '0;
    logic [15:0] b   = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cla_adder i_cla_adder (
        .a_i   (a),
        .b_i   (b),
        .cin_i (cin),
        .sum_o (sum),
        .cout_o(cout)
    );

    task automatic check(input logic [16:0] exp, input string tag);
        n_checks++;
        if ({cout, sum} !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     tag, a, b, cin, {cout, sum}, exp);
        end
    endtask

    task automatic apply(input logic [15:0] va, input logic [15:0] vb,
                         input logic vc, input logic [16:0] exp, input string tag);
        @(negedge clk);
        a = va; b = vb; cin = vc;
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    function automatic logic [16:0] model(input logic [15:0] va, input logic [15:0] vb,
                                          input logic vc);
        int unsigned t;
        t = int'(va) + int'(vb) + int'(vc);
        return t[16:0];
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(17'h0_0000, "R7 reset");
        @(negedge clk);
        rst = 1'b0;

        apply(16'h0000, 16'h0000, 1'b1, 17'h0_0001, "R7");
        apply(16'h0000, 16'hFFFF, 1'b0, 17'h0_FFFF, "R3");
        apply(16'h0000, 16'hFFFF, 1'b1, 17'h1_0000, "R3");
        apply(16'hFFFF, 16'h0000, 1'b1, 17'h1_0000, "R3");
        apply(16'h5555, 16'hAAAA, 1'b0, 17'h0_FFFF, "R4");
        apply(16'h5555, 16'hAAAA, 1'b1, 17'h1_0000, "R4");
        apply(16'hFFFF, 16'hFFFF, 1'b0, 17'h1_FFFE, "R6");
        apply(16'hFFFF, 16'hFFFF, 1'b1, 17'h1_FFFF, "R6");

        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = 16'h0008 << (4 * k);
            apply(v, v, 1'b0, {1'b0, v} << 1, "R2");
            apply(v, 16'h0000, 1'b1, model(v, 16'h0000, 1'b1), "R2");
            apply(16'h000F << (4 * k), 16'h0001 << (4 * k), 1'b0,
                  model(16'h000F << (4 * k), 16'h0001 << (4 * k), 1'b0), "R5");
        end

        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            logic        rc;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            apply(ra, rb, rc, model(ra, rb, rc), "R1");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule